// File: doc/BRIEF.md
# SCSI Target Selection Monitor

This block sits beside a SCSI target's bus transceivers. It watches the control lines and the data bus and decides when an initiator has selected one of the target IDs this device answers to. On a selection it takes over the bus by requesting that BSY be driven. A fixed time later it samples ATN to find out whether the host will follow with a message phase. A host that never raises ATN is classed as a legacy single-message host. The block also filters the bus RST line against glitches and holds a sticky bus-reset flag for the controller.

All bus inputs arrive asynchronously and pass through a two-flop synchronizer. Two delays are parameters given in nanoseconds: the ATN sampling delay and the RST filter window. They are turned into cycle counts from the clock frequency parameter. The controller ends a connection by pulsing a bus-free input, and it clears the reset flag with its own pulse. Command handling and phase sequencing after the selection belong to other blocks.

Top module: `scsi_sel_monitor`

## Requirements
- R1: A selection check starts when the condition "SEL asserted and BSY not asserted" becomes true. This covers both BSY released while SEL is held and SEL raised with BSY never asserted. SEL with BSY still asserted starts nothing.
- R2: Among the data bits that are set and whose ID is enabled in `id_en_i`, the lowest-numbered ID is selected. If no enabled ID is set, no selection is reported and BSY is not requested.
- R3: On a match, `sel_status_o` carries bit 4 = success, bit 3 = ATN flag (preset to 1), and bits 2:0 = selected ID. `bsy_drive_o` is 1 for as long as success is set.
- R4: While `bsy_drive_o` is 1, changes on SEL, BSY and the data bus leave the status unchanged.
- R5: ATN is sampled ATN_DELAY_NS after BSY is requested (5 cycles at the default 50 MHz). Until then the ATN flag reads 1. If ATN is low at the sample, the ATN flag clears and `legacy_host_o` becomes 1. If ATN is high, `legacy_host_o` becomes 0.
- R6: `was_selected_o` is set at detection and stays set even if SEL is dropped at once, until the connection is cleared.
- R7: A bus-reset event is raised only when RST is seen asserted at a rising edge and still asserted RST_FILT_NS later (25 cycles at the default). A shorter pulse is ignored.
- R8: `bus_reset_o` stays 1 after a reset event until `rst_flag_clr_i` is pulsed.
- R9: A `bus_free_i` pulse, a filtered bus-reset event, or the synchronous reset `rst` clears the status, `was_selected_o` and `bsy_drive_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Bus SEL, active high, asynchronous |
| bsy_i | input | 1 | Bus BSY, active high, asynchronous |
| atn_i | input | 1 | Bus ATN, active high, asynchronous |
| rst_bus_i | input | 1 | Bus RST, active high, asynchronous |
| data_i | input | NUM_IDS | Bus data lines, one per ID |
| id_en_i | input | NUM_IDS | Mask of IDs this device answers to |
| bus_free_i | input | 1 | Pulse: controller enters bus free |
| rst_flag_clr_i | input | 1 | Pulse: clear the bus-reset flag |
| sel_status_o | output | ID_W+2 | {success, ATN flag, ID} |
| was_selected_o | output | 1 | Latched selection indication |
| legacy_host_o | output | 1 | Host did not raise ATN at the last selection |
| bus_reset_o | output | 1 | Sticky filtered bus-reset flag |
| bsy_drive_o | output | 1 | Request to drive BSY |

## Verification
A table of selections with different data patterns and enable masks tells the lowest-ID priority apart from a plain first-match rule. Patterns with no enabled bit check that a failed selection never takes BSY. Each selection is run both with ATN held and without it, which checks the legacy classification and the ATN flag. Further tests compare the arbitration-style entry (BSY released under SEL) with a SEL-only entry, drop SEL after a short pulse, disturb the bus while the block holds BSY, check the ATN flag inside the sampling window, and compare RST pulses shorter and longer than the filter window.

// File: rtl/scsi_selmon_pkg.sv
package scsi_selmon_pkg;

  typedef enum logic [1:0] {
    SEL_IDLE     = 2'd0,
    SEL_ATN_WAIT = 2'd1,
    SEL_HOLD     = 2'd2
  } sel_state_t;

  // Cycles covering a delay in ns, rounded up, at least one.
  function automatic int ns_to_cycles(input int clk_hz, input int ns);
    longint c;
    c = (longint'(clk_hz) * longint'(ns) + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

endpackage

// File: rtl/scsi_sync2.sv
module scsi_sync2 #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] out_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[b] <= 1'b0;
        out_q[b]  <= 1'b0;
      end else begin
        meta_q[b] <= d_i[b];
        out_q[b]  <= meta_q[b];
      end
    end
  end

  assign q_o = out_q;
endmodule

// File: rtl/scsi_rst_filter.sv
module scsi_rst_filter #(
  parameter int FILT_CYC = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_s_i,
  input  logic clr_i,
  output logic det_o,
  output logic flag_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          prev_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          det_q;
  logic          flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= rst_s_i;
      det_q  <= 1'b0;
      if (!busy_q && rst_s_i && !prev_q) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(FILT_CYC - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          det_q  <= rst_s_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (det_q) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign det_o  = det_q;
  assign flag_o = flag_q;

  // R7: an event only follows a window that ends with RST still high
  a_r7_second_sample: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0 && !rst_s_i) |=> !det_q);

  // R8: the flag holds until cleared
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/scsi_sel_detect.sv
module scsi_sel_detect
  import scsi_selmon_pkg::*;
#(
  parameter int NUM_IDS  = 8,
  parameter int ATN_CYC  = 5,
  parameter int ID_W     = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_s_i,
  input  logic               bsy_s_i,
  input  logic               atn_s_i,
  input  logic [NUM_IDS-1:0] data_s_i,
  input  logic [NUM_IDS-1:0] id_en_i,
  input  logic               clr_i,
  output logic [ID_W+1:0]    status_o,
  output logic               was_sel_o,
  output logic               legacy_o,
  output logic               bsy_drive_o
);
  localparam int CW = $clog2(ATN_CYC + 1);

  sel_state_t    state_q;
  logic          cond_q;
  logic [CW-1:0] cnt_q;
  logic          succ_q;
  logic          atnf_q;
  logic [ID_W-1:0] id_q;
  logic          was_q;
  logic          legacy_q;
  logic          drive_q;

  logic            cond;
  logic            trig;
  logic            hit;
  logic [ID_W-1:0] hit_id;

  assign cond = sel_s_i & ~bsy_s_i;
  assign trig = cond & ~cond_q & (state_q == SEL_IDLE);

  // Lowest enabled ID with its data bit set wins
  always_comb begin
    hit    = 1'b0;
    hit_id = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (data_s_i[i] && id_en_i[i]) begin
        hit    = 1'b1;
        hit_id = ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEL_IDLE;
      cond_q   <= 1'b0;
      cnt_q    <= '0;
      succ_q   <= 1'b0;
      atnf_q   <= 1'b0;
      id_q     <= '0;
      was_q    <= 1'b0;
      legacy_q <= 1'b0;
      drive_q  <= 1'b0;
    end else begin
      cond_q <= cond;
      if (clr_i) begin
        state_q <= SEL_IDLE;
        succ_q  <= 1'b0;
        atnf_q  <= 1'b0;
        id_q    <= '0;
        was_q   <= 1'b0;
        drive_q <= 1'b0;
      end else begin
        case (state_q)
          SEL_IDLE: begin
            if (trig && hit) begin
              succ_q  <= 1'b1;
              atnf_q  <= 1'b1;
              id_q    <= hit_id;
              was_q   <= 1'b1;
              drive_q <= 1'b1;
              cnt_q   <= CW'(ATN_CYC - 1);
              state_q <= SEL_ATN_WAIT;
            end
          end
          SEL_ATN_WAIT: begin
            if (cnt_q == '0) begin
              atnf_q   <= atn_s_i;
              legacy_q <= ~atn_s_i;
              state_q  <= SEL_HOLD;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          SEL_HOLD: ;
          default: state_q <= SEL_IDLE;
        endcase
      end
    end
  end

  assign status_o    = {succ_q, atnf_q, id_q};
  assign was_sel_o   = was_q;
  assign legacy_o    = legacy_q;
  assign bsy_drive_o = drive_q;

  // R3: a reported success always comes with the BSY request
  a_r3_success_drives_bsy: assert property (@(posedge clk) disable iff (rst)
    succ_q |-> drive_q);

  // R4: the selected ID is frozen while BSY is held
  a_r4_hold_ignores_bus: assert property (@(posedge clk) disable iff (rst)
    (drive_q && !clr_i) |=> $stable(id_q) && drive_q);

  // R5: the ATN flag reads 1 until the sample is taken
  a_r5_atn_preset: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEL_ATN_WAIT) |-> atnf_q);

  // R2: a selection never starts without an enabled matching bit
  a_r2_needs_match: assert property (@(posedge clk) disable iff (rst)
    (state_q == SEL_IDLE && !hit) |=> !drive_q);

  // R9: a clear always drops the BSY request
  a_r9_clear_releases: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !drive_q && !was_q);
endmodule

// File: rtl/scsi_sel_monitor.sv
module scsi_sel_monitor
  import scsi_selmon_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int ATN_DELAY_NS = 100,
  parameter int RST_FILT_NS  = 500,
  parameter int NUM_IDS      = 8,
  parameter int ID_W         = $clog2(NUM_IDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_i,
  input  logic               bsy_i,
  input  logic               atn_i,
  input  logic               rst_bus_i,
  input  logic [NUM_IDS-1:0] data_i,
  input  logic [NUM_IDS-1:0] id_en_i,
  input  logic               bus_free_i,
  input  logic               rst_flag_clr_i,
  output logic [ID_W+1:0]    sel_status_o,
  output logic               was_selected_o,
  output logic               legacy_host_o,
  output logic               bus_reset_o,
  output logic               bsy_drive_o
);
  localparam int ATN_CYC  = ns_to_cycles(CLK_HZ, ATN_DELAY_NS);
  localparam int FILT_CYC = ns_to_cycles(CLK_HZ, RST_FILT_NS);
  localparam int SYNC_W   = NUM_IDS + 4;

  logic [SYNC_W-1:0]  raw_bus;
  logic [SYNC_W-1:0]  syn_bus;
  logic               rst_det;
  logic               sel_clr;

  assign raw_bus = {data_i, rst_bus_i, atn_i, bsy_i, sel_i};

  scsi_sync2 #(.WIDTH(SYNC_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_bus),
    .q_o (syn_bus)
  );

  scsi_rst_filter #(.FILT_CYC(FILT_CYC)) u_rstf (
    .clk     (clk),
    .rst     (rst),
    .rst_s_i (syn_bus[3]),
    .clr_i   (rst_flag_clr_i),
    .det_o   (rst_det),
    .flag_o  (bus_reset_o)
  );

  assign sel_clr = bus_free_i | rst_det;

  scsi_sel_detect #(
    .NUM_IDS (NUM_IDS),
    .ATN_CYC (ATN_CYC),
    .ID_W    (ID_W)
  ) u_seld (
    .clk         (clk),
    .rst         (rst),
    .sel_s_i     (syn_bus[0]),
    .bsy_s_i     (syn_bus[1]),
    .atn_s_i     (syn_bus[2]),
    .data_s_i    (syn_bus[SYNC_W-1:4]),
    .id_en_i     (id_en_i),
    .clr_i       (sel_clr),
    .status_o    (sel_status_o),
    .was_sel_o   (was_selected_o),
    .legacy_o    (legacy_host_o),
    .bsy_drive_o (bsy_drive_o)
  );
endmodule

// File: tb/scsi_sel_monitor_tb_top.sv
module scsi_sel_monitor_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_i = 0, bsy_i = 0, atn_i = 0, rst_bus_i = 0;
  logic [7:0] data_i = 0, id_en_i = 0;
  logic bus_free_i = 0, rst_flag_clr_i = 0;
  logic [4:0] sel_status_o;
  logic was_selected_o, legacy_host_o, bus_reset_o, bsy_drive_o;

  int checks = 0;
  int fails  = 0;
  logic exp_leg = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_sel_monitor dut_i (
    .clk(clk), .rst(rst), .sel_i(sel_i), .bsy_i(bsy_i), .atn_i(atn_i),
    .rst_bus_i(rst_bus_i), .data_i(data_i), .id_en_i(id_en_i),
    .bus_free_i(bus_free_i), .rst_flag_clr_i(rst_flag_clr_i),
    .sel_status_o(sel_status_o), .was_selected_o(was_selected_o),
    .legacy_host_o(legacy_host_o), .bus_reset_o(bus_reset_o),
    .bsy_drive_o(bsy_drive_o)
  );

  // {data, enable, atn}
  localparam logic [16:0] VECS [0:NV-1] = '{
    {8'h08, 8'hFF, 1'b1},
    {8'hA4, 8'hFF, 1'b0},
    {8'hA4, 8'hA0, 1'b1},
    {8'h80, 8'h7F, 1'b1},
    {8'h81, 8'h80, 1'b0},
    {8'h00, 8'hFF, 1'b1},
    {8'h01, 8'h01, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic free_bus();
    bus_free_i = 1'b1;
    cyc(1);
    bus_free_i = 1'b0;
    sel_i = 1'b0; bsy_i = 1'b0; data_i = '0;
    cyc(4);
  endtask

  function automatic int lowest_id(input logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return -1;
  endfunction

  initial begin
    cyc(100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(4);
    // R9: reset state
    chk("R9 reset status", sel_status_o, 0);
    chk("R9 reset bsy", bsy_drive_o, 0);
    chk("R8 reset flag", bus_reset_o, 0);
    rst = 1'b0;
    cyc(3);

    // R1 R2 R3 R5: table of selections (SEL-only entry)
    for (int v = 0; v < NV; v++) begin
      logic [7:0] d, e;
      logic a;
      int id;
      {d, e, a} = VECS[v];
      id = lowest_id(d & e);
      id_en_i = e; atn_i = a; data_i = d; bsy_i = 1'b0;
      cyc(1);
      sel_i = 1'b1;
      cyc(14);
      if (id >= 0) begin
        exp_leg = ~a;
        chk("R2 R3 status", sel_status_o, {1'b1, a, 3'(id)});
        chk("R3 bsy drive", bsy_drive_o, 1);
        chk("R5 legacy", legacy_host_o, exp_leg);
      end else begin
        chk("R2 no match status", sel_status_o, 0);
        chk("R2 no match bsy", bsy_drive_o, 0);
        chk("R5 legacy kept", legacy_host_o, exp_leg);
      end
      free_bus();
      chk("R9 bus free status", sel_status_o, 0);
      chk("R9 bus free bsy", bsy_drive_o, 0);
    end

    // R1: SEL with BSY held starts nothing, BSY release starts the selection
    id_en_i = 8'hFF; atn_i = 1'b1; data_i = 8'h40; bsy_i = 1'b1; sel_i = 1'b1;
    cyc(10);
    chk("R1 bsy held no select", bsy_drive_o, 0);
    bsy_i = 1'b0;
    cyc(10);
    chk("R1 bsy release select", sel_status_o, {2'b11, 3'd6});

    // R4: bus activity while holding BSY is ignored
    sel_i = 1'b0; cyc(3);
    data_i = 8'h02; sel_i = 1'b1; cyc(10);
    chk("R4 status frozen", sel_status_o, {2'b11, 3'd6});
    free_bus();

    // R6: short SEL pulse still selects, flag stays
    atn_i = 1'b0; data_i = 8'h10;
    cyc(1);
    sel_i = 1'b1; cyc(2); sel_i = 1'b0;
    cyc(12);
    chk("R6 was selected", was_selected_o, 1);
    chk("R6 status after SEL drop", sel_status_o, {2'b10, 3'd4});
    free_bus();
    chk("R6 cleared by bus free", was_selected_o, 0);

    // R5: ATN flag stays 1 inside the sampling window, then clears
    atn_i = 1'b0; data_i = 8'h04;
    cyc(1);
    sel_i = 1'b1;
    while (!bsy_drive_o) cyc(1);
    cyc(2);
    chk("R5 atn flag in window", sel_status_o[3], 1);
    cyc(8);
    chk("R5 atn flag after sample", sel_status_o[3], 0);
    chk("R5 legacy set", legacy_host_o, 1);

    // R7 R9: short RST pulse ignored; long pulse flags and clears selection
    rst_bus_i = 1'b1; cyc(5); rst_bus_i = 1'b0;
    cyc(40);
    chk("R7 glitch ignored", bus_reset_o, 0);
    chk("R7 glitch keeps selection", bsy_drive_o, 1);
    rst_bus_i = 1'b1; cyc(40);
    chk("R7 long reset flagged", bus_reset_o, 1);
    chk("R9 reset clears bsy", bsy_drive_o, 0);
    chk("R9 reset clears status", sel_status_o, 0);
    rst_bus_i = 1'b0; sel_i = 1'b0;
    cyc(10);
    // R8: sticky until cleared
    chk("R8 flag sticky", bus_reset_o, 1);
    rst_flag_clr_i = 1'b1; cyc(1); rst_flag_clr_i = 1'b0;
    cyc(2);
    chk("R8 flag cleared", bus_reset_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule